// File: doc/BRIEF.md
# Beam Destination Arbiter

This block decides, once per injector super-cycle, where a collider-bound beam is sent. A one-cycle strobe marks each evaluation. On it the arbiter looks at the interlock status, the operator user request, the two dump-line requests with their in-place status, the two ring transfer-line inhibits and, when the sequencer holds mastership, the pending fill request. It then registers a destination code, a batch count, per-batch injection markers, per-batch kill signals for the linac tail clipper and the upstream dump, and an extraction enable.

Mastership is held inside the block. The sequencer asks for it, or gives it up, through a request pulse. The arbiter grants the request with an acknowledge pulse or refuses it with an error pulse, according to the user request and an external allow bit. A fill request names a ring, an RF bucket and a batch count. It is accepted only while the sequencer is master, and it is used up by the next evaluation, whatever that evaluation decides.

Top module: `beam_dest_arb`

## Requirements
- R1: When `ilk_ok` is low at an evaluation, the result is spare (`dest`=0), with `batch_cnt`=0, no markers, no kills and `extract`=0.
- R2: When `user_req` is low at an evaluation, the result is spare, whether or not the sequencer is master.
- R3: When the sequencer is not master, dump line A (`dest`=3) is chosen if `dump_req_a` and `dump_in_a` are both high. Otherwise dump line B (`dest`=4) is chosen if `dump_req_b` and `dump_in_b` are both high. A request for line A takes precedence over line B. If the selected dump line is requested but not in place, the result is spare. Dump-line destinations have `extract`=1.
- R4: When the sequencer is not master and neither dump line is requested, the destination is the main accelerator dump (`dest`=5) with `extract`=0. In every non-master case `batch_cnt` equals `op_nbatch`. An `op_nbatch` outside 1..MAX_BATCH gives spare.
- R5: When the sequencer is master and a valid fill request is pending, the destination is ring line 1 (`dest`=1, `fill_ring`=0) or ring line 2 (`dest`=2, `fill_ring`=1). In that case `batch_cnt` is the request's count, `bucket_out` is its bucket, and `extract`=1.
- R6: A pending request whose ring line is inhibited (`inhib_r1` or `inhib_r2`) gives spare.
- R7: When the sequencer is master and no request is pending, the destination is the main dump with `batch_cnt`=MAX_BATCH and `extract`=0. Every batch has its kill bit set in both `kill_clip` and `kill_dump`, and every batch still has its marker set in `inj_mark`.
- R8: A pending request is used by exactly one evaluation. The next evaluation without a new request behaves as R7.
- R9: A request with a bucket of 35640 or more, or with a count outside 1..MAX_BATCH, gives spare and is still used up.
- R10: A mastership request (`mast_req`, with `mast_take`=1 to take and 0 to give up) is refused with a one-cycle `mast_err` while `user_req` is high, or when taking without `mast_allow`. Otherwise `is_master` becomes `mast_take` with a one-cycle `mast_ack`. A refused request leaves `is_master` unchanged.
- R11: After reset the block is not master, has no pending request, and shows `dest`=0, `out_valid`=0, a zero count, no markers, no kills and `extract`=0.
- R12: A `fill_load` while the sequencer is not master is ignored. Once mastership is later taken, the first evaluation behaves as R7.
- R13: `inj_mark` bit i (batch i+1) is set exactly when i < `batch_cnt`. `out_valid` pulses for one cycle after each evaluation, and the results hold between evaluations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Super-cycle evaluation strobe |
| ilk_ok | input | 1 | High when all interlocks are normal |
| user_req | input | 1 | Operator user request for the collider beam |
| dump_req_a | input | 1 | Request for dump line A |
| dump_req_b | input | 1 | Request for dump line B |
| dump_in_a | input | 1 | Dump A is in place |
| dump_in_b | input | 1 | Dump B is in place |
| inhib_r1 | input | 1 | Ring 1 transfer line inhibited |
| inhib_r2 | input | 1 | Ring 2 transfer line inhibited |
| op_nbatch | input | CNT_W | Operator batch count when not master |
| fill_load | input | 1 | Load a fill request |
| fill_ring | input | 1 | Ring of the request (0 = ring 1, 1 = ring 2) |
| fill_bucket | input | BKT_W | RF bucket of the request |
| fill_nbatch | input | CNT_W | Batch count of the request |
| mast_req | input | 1 | Mastership change request |
| mast_take | input | 1 | 1 = take mastership, 0 = give it up |
| mast_allow | input | 1 | Allow bit for taking mastership |
| is_master | output | 1 | Sequencer currently master |
| mast_ack | output | 1 | Mastership request granted (one-cycle pulse) |
| mast_err | output | 1 | Mastership request refused (one-cycle pulse) |
| out_valid | output | 1 | Pulse: new result registered |
| dest | output | 3 | Destination code (0 spare, 1 ring 1, 2 ring 2, 3 dump A, 4 dump B, 5 main dump) |
| batch_cnt | output | CNT_W | Batches played this cycle |
| inj_mark | output | MAX_BATCH | Per-batch injection timing marker |
| kill_clip | output | MAX_BATCH | Per-batch tail-clipper kill |
| kill_dump | output | MAX_BATCH | Per-batch upstream-dump kill |
| extract | output | 1 | Extraction timing enabled |
| bucket_out | output | BKT_W | RF bucket for ring-line injection |

## Verification
Every routing result is registered by the clock edge that samples `cyc_start`, so it is due one cycle after the strobe. Mastership acknowledge, error and state changes are also due one cycle after `mast_req`. A stored fill request takes effect only at the evaluation that follows its load cycle. The bench drives inputs on falling edges and reads outputs on the falling edge after the capturing rising edge, which places every comparison exactly one register stage after its stimulus. It also confirms that `out_valid` has dropped and that the results hold on a cycle without a strobe.

// File: rtl/bda_pkg.sv
package bda_pkg;
   typedef enum logic [2:0] {
      DST_SPARE = 3'd0,
      DST_RING1 = 3'd1,
      DST_RING2 = 3'd2,
      DST_DUMPA = 3'd3,
      DST_DUMPB = 3'd4,
      DST_MAIN  = 3'd5
   } dest_e;
endpackage

// File: rtl/bda_mastership.sv
module bda_mastership (
   input  logic clk,
   input  logic rst_n,
   input  logic mast_req,
   input  logic mast_take,
   input  logic mast_allow,
   input  logic user_req,
   output logic master,
   output logic ack,
   output logic err
);
   logic refuse;
   assign refuse = user_req | (mast_take & ~mast_allow);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         master <= 1'b0;
         ack    <= 1'b0;
         err    <= 1'b0;
      end else begin
         ack <= 1'b0;
         err <= 1'b0;
         if (mast_req) begin
            if (refuse) begin
               err <= 1'b1;
            end else begin
               master <= mast_take;
               ack    <= 1'b1;
            end
         end
      end
   end

   // R10
   mast_user_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (master != $past(master)) |-> !$past(user_req));
   // R10
   mast_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(master) |-> $past(mast_allow));
   // R10
   mast_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack && err));
endmodule

// File: rtl/bda_fill_slot.sv
module bda_fill_slot #(
   parameter int BKT_W = 16,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             master,
   input  logic             consume,
   input  logic             load,
   input  logic             ld_ring,
   input  logic [BKT_W-1:0] ld_bucket,
   input  logic [CNT_W-1:0] ld_nbatch,
   output logic             pend_valid,
   output logic             pend_ring,
   output logic [BKT_W-1:0] pend_bucket,
   output logic [CNT_W-1:0] pend_nbatch
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_valid  <= 1'b0;
         pend_ring   <= 1'b0;
         pend_bucket <= '0;
         pend_nbatch <= '0;
      end else if (!master) begin
         pend_valid <= 1'b0;
      end else begin
         if (consume) pend_valid <= 1'b0;
         if (load) begin
            pend_valid  <= 1'b1;
            pend_ring   <= ld_ring;
            pend_bucket <= ld_bucket;
            pend_nbatch <= ld_nbatch;
         end
      end
   end

   // R8
   fill_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (consume && !load) |=> !pend_valid);
   // R12
   fill_nomaster_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !master |=> !pend_valid);
endmodule

// File: rtl/bda_route.sv
module bda_route
   import bda_pkg::*;
#(
   parameter int MAX_BATCH = 4,
   parameter int NBUCKET   = 35640,
   parameter int BKT_W     = 16,
   parameter int CNT_W     = 3
) (
   input  logic                 master,
   input  logic                 ilk_ok,
   input  logic                 user_req,
   input  logic                 dump_req_a,
   input  logic                 dump_req_b,
   input  logic                 dump_in_a,
   input  logic                 dump_in_b,
   input  logic                 inhib_r1,
   input  logic                 inhib_r2,
   input  logic [CNT_W-1:0]     op_nbatch,
   input  logic                 pend_valid,
   input  logic                 pend_ring,
   input  logic [BKT_W-1:0]     pend_bucket,
   input  logic [CNT_W-1:0]     pend_nbatch,
   output dest_e                r_dest,
   output logic [CNT_W-1:0]     r_cnt,
   output logic [MAX_BATCH-1:0] r_mark,
   output logic [MAX_BATCH-1:0] r_kill,
   output logic                 r_extract,
   output logic [BKT_W-1:0]     r_bucket
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MAX_BATCH);

   logic op_cnt_ok, pend_cnt_ok, bucket_ok, line_inhib, kill_all;

   assign op_cnt_ok   = (op_nbatch != '0) && (op_nbatch <= FULL_CNT);
   assign pend_cnt_ok = (pend_nbatch != '0) && (pend_nbatch <= FULL_CNT);
   assign bucket_ok   = (32'(pend_bucket) < NBUCKET);
   assign line_inhib  = pend_ring ? inhib_r2 : inhib_r1;

   always_comb begin
      r_dest    = DST_SPARE;
      r_cnt     = '0;
      r_extract = 1'b0;
      r_bucket  = '0;
      kill_all  = 1'b0;
      if (ilk_ok && user_req) begin
         if (!master) begin
            if (op_cnt_ok) begin
               if (dump_req_a) begin
                  if (dump_in_a) begin
                     r_dest    = DST_DUMPA;
                     r_cnt     = op_nbatch;
                     r_extract = 1'b1;
                  end
               end else if (dump_req_b) begin
                  if (dump_in_b) begin
                     r_dest    = DST_DUMPB;
                     r_cnt     = op_nbatch;
                     r_extract = 1'b1;
                  end
               end else begin
                  r_dest = DST_MAIN;
                  r_cnt  = op_nbatch;
               end
            end
         end else if (pend_valid) begin
            if (bucket_ok && pend_cnt_ok && !line_inhib) begin
               r_dest    = pend_ring ? DST_RING2 : DST_RING1;
               r_cnt     = pend_nbatch;
               r_extract = 1'b1;
               r_bucket  = pend_bucket;
            end
         end else begin
            r_dest   = DST_MAIN;
            r_cnt    = FULL_CNT;
            kill_all = 1'b1;
         end
      end
   end

   for (genvar i = 0; i < MAX_BATCH; i++) begin : g_batch
      assign r_mark[i] = (32'(r_cnt) > i);
      assign r_kill[i] = kill_all;
   end
endmodule

// File: rtl/beam_dest_arb.sv
module beam_dest_arb
   import bda_pkg::*;
#(
   parameter int MAX_BATCH = 4,
   parameter int NBUCKET   = 35640,
   parameter int BKT_W     = 16,
   parameter int CNT_W     = $clog2(MAX_BATCH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cyc_start,
   input  logic                 ilk_ok,
   input  logic                 user_req,
   input  logic                 dump_req_a,
   input  logic                 dump_req_b,
   input  logic                 dump_in_a,
   input  logic                 dump_in_b,
   input  logic                 inhib_r1,
   input  logic                 inhib_r2,
   input  logic [CNT_W-1:0]     op_nbatch,
   input  logic                 fill_load,
   input  logic                 fill_ring,
   input  logic [BKT_W-1:0]     fill_bucket,
   input  logic [CNT_W-1:0]     fill_nbatch,
   input  logic                 mast_req,
   input  logic                 mast_take,
   input  logic                 mast_allow,
   output logic                 is_master,
   output logic                 mast_ack,
   output logic                 mast_err,
   output logic                 out_valid,
   output logic [2:0]           dest,
   output logic [CNT_W-1:0]     batch_cnt,
   output logic [MAX_BATCH-1:0] inj_mark,
   output logic [MAX_BATCH-1:0] kill_clip,
   output logic [MAX_BATCH-1:0] kill_dump,
   output logic                 extract,
   output logic [BKT_W-1:0]     bucket_out
);
   if (MAX_BATCH < 1 || MAX_BATCH > 15) begin : g_bad_batch
      $error("MAX_BATCH out of range");
   end
   if (NBUCKET < 1 || NBUCKET > (1 << BKT_W)) begin : g_bad_bucket
      $error("NBUCKET does not fit BKT_W");
   end
   if ((1 << CNT_W) <= MAX_BATCH) begin : g_bad_cnt
      $error("CNT_W too narrow");
   end

   logic                 pend_valid, pend_ring;
   logic [BKT_W-1:0]     pend_bucket;
   logic [CNT_W-1:0]     pend_nbatch;
   dest_e                r_dest;
   logic [CNT_W-1:0]     r_cnt;
   logic [MAX_BATCH-1:0] r_mark, r_kill;
   logic                 r_extract;
   logic [BKT_W-1:0]     r_bucket;

   bda_mastership u_mast (
      .clk(clk), .rst_n(rst_n), .mast_req(mast_req), .mast_take(mast_take),
      .mast_allow(mast_allow), .user_req(user_req), .master(is_master),
      .ack(mast_ack), .err(mast_err)
   );

   bda_fill_slot #(.BKT_W(BKT_W), .CNT_W(CNT_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .master(is_master),
      .consume(cyc_start & is_master), .load(fill_load & is_master),
      .ld_ring(fill_ring), .ld_bucket(fill_bucket), .ld_nbatch(fill_nbatch),
      .pend_valid(pend_valid), .pend_ring(pend_ring),
      .pend_bucket(pend_bucket), .pend_nbatch(pend_nbatch)
   );

   bda_route #(.MAX_BATCH(MAX_BATCH), .NBUCKET(NBUCKET), .BKT_W(BKT_W),
               .CNT_W(CNT_W)) u_route (
      .master(is_master), .ilk_ok(ilk_ok), .user_req(user_req),
      .dump_req_a(dump_req_a), .dump_req_b(dump_req_b),
      .dump_in_a(dump_in_a), .dump_in_b(dump_in_b),
      .inhib_r1(inhib_r1), .inhib_r2(inhib_r2), .op_nbatch(op_nbatch),
      .pend_valid(pend_valid), .pend_ring(pend_ring),
      .pend_bucket(pend_bucket), .pend_nbatch(pend_nbatch),
      .r_dest(r_dest), .r_cnt(r_cnt), .r_mark(r_mark), .r_kill(r_kill),
      .r_extract(r_extract), .r_bucket(r_bucket)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         dest       <= DST_SPARE;
         batch_cnt  <= '0;
         inj_mark   <= '0;
         kill_clip  <= '0;
         kill_dump  <= '0;
         extract    <= 1'b0;
         bucket_out <= '0;
      end else begin
         out_valid <= cyc_start;
         if (cyc_start) begin
            dest       <= r_dest;
            batch_cnt  <= r_cnt;
            inj_mark   <= r_mark;
            kill_clip  <= r_kill;
            kill_dump  <= r_kill;
            extract    <= r_extract;
            bucket_out <= r_bucket;
         end
      end
   end

   // R1
   ilk_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !ilk_ok) |=> (dest == DST_SPARE && batch_cnt == '0));
   // R5
   ring_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !is_master) |=> (dest != DST_RING1 && dest != DST_RING2));
   // R7
   kill_noext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|kill_clip) |-> (!extract && dest == DST_MAIN));
   // R13
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_start |=> $stable(dest) && $stable(batch_cnt));
endmodule

// File: tb/beam_dest_arb_bench.sv
`timescale 1ns/1ps
module beam_dest_arb_bench;
   localparam int MAXB = 4;
   localparam int CW   = 3;
   localparam int BW   = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_start = 0, ilk_ok = 0, user_req = 0;
   logic dump_req_a = 0, dump_req_b = 0, dump_in_a = 0, dump_in_b = 0;
   logic inhib_r1 = 0, inhib_r2 = 0;
   logic [CW-1:0] op_nbatch = '0;
   logic fill_load = 0, fill_ring = 0;
   logic [BW-1:0] fill_bucket = '0;
   logic [CW-1:0] fill_nbatch = '0;
   logic mast_req = 0, mast_take = 0, mast_allow = 0;
   logic is_master, mast_ack, mast_err, out_valid, extract;
   logic [2:0] dest;
   logic [CW-1:0] batch_cnt;
   logic [MAXB-1:0] inj_mark, kill_clip, kill_dump;
   logic [BW-1:0] bucket_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #2.5 clk = ~clk;

   beam_dest_arb u_beam_dest_arb (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .ilk_ok(ilk_ok),
      .user_req(user_req), .dump_req_a(dump_req_a), .dump_req_b(dump_req_b),
      .dump_in_a(dump_in_a), .dump_in_b(dump_in_b), .inhib_r1(inhib_r1),
      .inhib_r2(inhib_r2), .op_nbatch(op_nbatch), .fill_load(fill_load),
      .fill_ring(fill_ring), .fill_bucket(fill_bucket),
      .fill_nbatch(fill_nbatch), .mast_req(mast_req), .mast_take(mast_take),
      .mast_allow(mast_allow), .is_master(is_master), .mast_ack(mast_ack),
      .mast_err(mast_err), .out_valid(out_valid), .dest(dest),
      .batch_cnt(batch_cnt), .inj_mark(inj_mark), .kill_clip(kill_clip),
      .kill_dump(kill_dump), .extract(extract), .bucket_out(bucket_out)
   );

   // {ilk, user, dra, drb, dia, dib, op_n[2:0], exp_dest[2:0], exp_cnt[2:0], exp_ext}
   localparam logic [15:0] VEC [10] = '{
      {6'b110000, 3'd3, 3'd5, 3'd3, 1'b0},   // R4 main dump
      {6'b010000, 3'd3, 3'd0, 3'd0, 1'b0},   // R1 interlock
      {6'b100000, 3'd3, 3'd0, 3'd0, 1'b0},   // R2 no user request
      {6'b111010, 3'd2, 3'd3, 3'd2, 1'b1},   // R3 dump A
      {6'b111001, 3'd2, 3'd0, 3'd0, 1'b0},   // R3 A requested, not in place
      {6'b110101, 3'd4, 3'd4, 3'd4, 1'b1},   // R3 dump B
      {6'b111111, 3'd1, 3'd3, 3'd1, 1'b1},   // R3 A before B
      {6'b110011, 3'd0, 3'd0, 3'd0, 1'b0},   // R4 zero count
      {6'b110000, 3'd5, 3'd0, 3'd0, 1'b0},   // R4 count too large
      {6'b011010, 3'd2, 3'd0, 3'd0, 1'b0}    // R1 interlock over dump
   };

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int low_mask(input int n);
      return (1 << n) - 1;
   endfunction

   task automatic evaluate();
      @(negedge clk) cyc_start = 1'b1;
      @(negedge clk) cyc_start = 1'b0;
   endtask

   task automatic expect_out(input string tag, input int d, input int c,
                             input int ext, input int kill);
      check({tag, " valid"}, out_valid, 1);
      check({tag, " dest"}, dest, d);
      check({tag, " cnt"}, batch_cnt, c);
      check({tag, " extract"}, extract, ext);
      check({tag, " mark R13"}, inj_mark, low_mask(c));
      check({tag, " kill_clip"}, kill_clip, kill);
      check({tag, " kill_dump"}, kill_dump, kill);
   endtask

   task automatic mast(input logic take, input logic allow);
      @(negedge clk) begin mast_req = 1'b1; mast_take = take; mast_allow = allow; end
      @(negedge clk) mast_req = 1'b0;
   endtask

   task automatic load_fill(input logic ring, input int bkt, input int nb);
      @(negedge clk) begin
         fill_load = 1'b1; fill_ring = ring;
         fill_bucket = BW'(bkt); fill_nbatch = CW'(nb);
      end
      @(negedge clk) fill_load = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 master", is_master, 0);
      check("R11 dest", dest, 0);
      check("R11 valid", out_valid, 0);
      check("R11 cnt", batch_cnt, 0);
      check("R11 kill", kill_clip | kill_dump, 0);
      check("R11 mark", inj_mark, 0);
      check("R11 extract", extract, 0);

      // table of non-master routing vectors (R1..R4)
      for (int i = 0; i < 10; i++) begin
         @(negedge clk) begin
            {ilk_ok, user_req, dump_req_a, dump_req_b, dump_in_a, dump_in_b} = VEC[i][15:10];
            op_nbatch = VEC[i][9:7];
         end
         evaluate();
         expect_out($sformatf("R1-4 vec%0d", i), VEC[i][6:4], VEC[i][3:1], VEC[i][0], 0);
      end

      // R13 hold without strobe
      @(negedge clk);
      check("R13 valid drops", out_valid, 0);
      check("R13 dest held", dest, 0);

      // R12 fill ignored when not master
      @(negedge clk) begin ilk_ok = 1; user_req = 0; dump_req_a = 0; dump_req_b = 0; op_nbatch = 3'd2; end
      load_fill(1'b0, 100, 2);
      // R10 refused: allow low
      @(negedge clk) begin mast_req = 1; mast_take = 1; mast_allow = 0; end
      @(negedge clk) mast_req = 0;
      check("R10 err no allow", mast_err, 1);
      check("R10 master unchanged", is_master, 0);
      // R10 refused: user request high
      @(negedge clk) user_req = 1;
      @(negedge clk) begin mast_req = 1; mast_take = 1; mast_allow = 1; end
      @(negedge clk) mast_req = 0;
      check("R10 err user", mast_err, 1);
      check("R10 no ack", mast_ack, 0);
      check("R10 master unchanged 2", is_master, 0);
      // R10 granted
      @(negedge clk) user_req = 0;
      @(negedge clk) begin mast_req = 1; mast_take = 1; mast_allow = 1; end
      @(negedge clk) mast_req = 0;
      check("R10 ack", mast_ack, 1);
      check("R10 master set", is_master, 1);
      @(negedge clk) user_req = 1;
      evaluate();
      expect_out("R12 no pending", 5, MAXB, 0, low_mask(MAXB));

      // R5 ring 1
      load_fill(1'b0, 100, 3);
      evaluate();
      expect_out("R5 ring1", 1, 3, 1, 0);
      check("R5 bucket", bucket_out, 100);
      // R8 consumed, R7 kill all
      evaluate();
      expect_out("R8 R7 kill", 5, MAXB, 0, low_mask(MAXB));

      // R6 inhibited ring 2
      @(negedge clk) inhib_r2 = 1;
      load_fill(1'b1, 35639, 4);
      evaluate();
      expect_out("R6 inhibit", 0, 0, 0, 0);
      @(negedge clk) inhib_r2 = 0;
      evaluate();
      expect_out("R8 after spare", 5, MAXB, 0, low_mask(MAXB));

      // R5 ring 2, last bucket
      load_fill(1'b1, 35639, 4);
      evaluate();
      expect_out("R5 ring2", 2, 4, 1, 0);
      check("R5 bucket max", bucket_out, 35639);

      // R9 invalid bucket, invalid count
      load_fill(1'b0, 35640, 2);
      evaluate();
      expect_out("R9 bucket", 0, 0, 0, 0);
      load_fill(1'b0, 5, 0);
      evaluate();
      expect_out("R9 count", 0, 0, 0, 0);
      evaluate();
      expect_out("R9 consumed", 5, MAXB, 0, low_mask(MAXB));

      // R1 interlock with pending as master
      load_fill(1'b0, 7, 1);
      @(negedge clk) ilk_ok = 0;
      evaluate();
      expect_out("R1 master", 0, 0, 0, 0);
      @(negedge clk) ilk_ok = 1;
      // R2 master, no user request
      @(negedge clk) user_req = 0;
      evaluate();
      expect_out("R2 master", 0, 0, 0, 0);

      // R10 release refused while user high, then granted
      @(negedge clk) user_req = 1;
      mast(1'b0, 1'b0);
      check("R10 release err", mast_err, 1);
      check("R10 still master", is_master, 1);
      @(negedge clk) user_req = 0;
      mast(1'b0, 1'b0);
      check("R10 release ack", mast_ack, 1);
      check("R10 released", is_master, 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule